// File: doc/BRIEF.md
# Supervisory Reset Generator with Serial-Bus Watchdog

This block drives a system reset from three causes: the power-on release, a digital flag from an external low-supply comparator, and expiry of a watchdog. The watchdog is not fed through a pin of its own. It observes the two lines of a two-wire serial bus and takes every start condition as a sign of life: SDA falling while SCL is high. A two-bit code picks one of three watchdog periods, or turns the watchdog off.

Each reset cause keeps the reset asserted for a fixed hold time after the cause has gone away. While the reset is asserted, the block raises a bus-inhibit flag. Neighbouring serial and nonvolatile logic uses that flag to drop any transfer in progress and to refuse new ones. All time constants are parameters counted in clock cycles. A polarity parameter selects an active-low or an active-high reset output.

Top module: `sup_reset_gen`

## Requirements
- R1: While `por_n` is low, the reset is asserted. With `low_flag` clear, the reset deasserts on exactly the (RST_HOLD_CYC+2)-th rising clock edge after `por_n` rises.
- R2: A high `low_flag` asserts the reset in the same cycle, through a combinational path. The reset stays asserted for as long as the flag is high, however long that is.
- R3: After `low_flag` falls, the reset deasserts on exactly the (RST_HOLD_CYC+2)-th rising edge.
- R4: A start condition restarts the watchdog. A start condition is SDA going from 1 to 0 while SCL is 1. When the watchdog is not restarted again, it expires and the reset asserts on the (P+3)-th rising edge after the SDA fall, where P is the selected period.
- R5: Other line activity does not restart the watchdog. This covers SDA falling while SCL is low, SDA rising while SCL is high, and SCL toggling. Expiry keeps its original schedule.
- R6: The value of `wd_code` selects the period P in cycles: 2'b00 gives WD_LONG_CYC, 2'b01 gives WD_MID_CYC and 2'b10 gives WD_SHORT_CYC. With no start condition, the reset reasserts exactly P rising edges after the reset was released.
- R7: `wd_code` = 2'b11 turns the watchdog off, and no watchdog reset occurs.
- R8: A watchdog expiry asserts the reset for exactly RST_HOLD_CYC rising edges.
- R9: A change of `wd_code` clears the watchdog count on the next edge. Expiry then follows on the (P_new+1)-th rising edge after the new code is applied.
- R10: While the reset is asserted, start conditions are ignored. The watchdog stays at zero and counts its full period from the release.
- R11: `bus_block` is 1 exactly when the reset is asserted. The output `sys_rst` is low-true when RST_ACTIVE_HIGH = 0 and high-true when RST_ACTIVE_HIGH = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, low while the supply ramps |
| low_flag | input | 1 | Low-supply comparator flag, high when the supply is below the trip level |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| wd_code | input | 2 | Watchdog period select; 2'b11 turns the watchdog off |
| sys_rst | output | 1 | System reset, polarity set by RST_ACTIVE_HIGH |
| bus_block | output | 1 | High while reset is asserted, to inhibit serial transfers and new writes |

## Verification
Genuine start conditions are contrasted with look-alike line activity: SDA falls with SCL low, stop conditions, and bare SCL toggles. The aim is to show that only the true start moves the expiry edge. Expiry is measured to the exact cycle after the power-on release, after a low-flag release, after a kick, and after a code change. Each measurement separates one of the distinct latencies (P, P+1, P+3, HOLD+2), so an off-by-one in any path shows up. Random kick trains with gaps up to a full period, under randomly chosen codes, confirm that the reset never fires early. A kick driven while the reset is asserted confirms that it is ignored.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

  typedef enum logic [1:0] {
    WD_PER_LONG  = 2'b00,
    WD_PER_MID   = 2'b01,
    WD_PER_SHORT = 2'b10,
    WD_PER_OFF   = 2'b11
  } wd_code_e;

  // Largest of three cycle counts, used to size the watchdog counter.
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Period in cycles selected by a watchdog code; 0 when the watchdog is off.
  function automatic int unsigned wd_period(input logic [1:0] code,
                                            input int unsigned long_c,
                                            input int unsigned mid_c,
                                            input int unsigned short_c);
    case (code)
      WD_PER_LONG:  return long_c;
      WD_PER_MID:   return mid_c;
      WD_PER_SHORT: return short_c;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sup_start_det.sv
module sup_start_det (
  input  logic clk,
  input  logic arst_n,
  input  logic enable,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt
);
  logic sda_prev;
  logic scl_prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sda_prev <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_prev <= sda_s;
      scl_prev <= scl_s;
    end
  end

  // SDA high-to-low while SCL has been high on both samples
  assign start_evt = enable & scl_s & scl_prev & sda_prev & ~sda_s;
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int unsigned HOLD_CYC = 16,
  localparam int unsigned HW = $clog2(HOLD_CYC + 1)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          trig,
  output logic          active,
  output logic [HW-1:0] cnt
);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (trig) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + HW'(1);
      end
    end
  end
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_reset_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 1400,
  parameter int unsigned MID_CYC   = 600,
  parameter int unsigned SHORT_CYC = 200,
  localparam int unsigned CW = $clog2(max3(LONG_CYC, MID_CYC, SHORT_CYC) + 1)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          hold,
  input  logic          kick,
  input  logic [1:0]    code,
  output logic          expire,
  output logic          run,
  output logic          code_chg,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim
);
  logic [1:0] code_q;
  logic       clr;

  always_comb begin
    lim      = CW'(wd_period(code, LONG_CYC, MID_CYC, SHORT_CYC));
    run      = (code != WD_PER_OFF);
    code_chg = (code != code_q);
    expire   = ~hold & run & ~code_chg & ~kick & (cnt == lim - CW'(1));
    clr      = hold | ~run | code_chg | kick | expire;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      code_q <= WD_PER_OFF;
      cnt    <= '0;
    end else begin
      code_q <= code;
      if (clr) cnt <= '0;
      else     cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_reset_pkg::*;
#(
  parameter bit          RST_ACTIVE_HIGH = 1'b0,
  parameter int unsigned RST_HOLD_CYC    = 250000,
  parameter int unsigned WD_LONG_CYC     = 1400000,
  parameter int unsigned WD_MID_CYC      = 600000,
  parameter int unsigned WD_SHORT_CYC    = 200000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       low_flag,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] wd_code,
  output logic       sys_rst,
  output logic       bus_block
);
  localparam int unsigned CW = $clog2(max3(WD_LONG_CYC, WD_MID_CYC, WD_SHORT_CYC) + 1);
  localparam int unsigned HW = $clog2(RST_HOLD_CYC + 1);

  logic          scl_s, sda_s, low_s;
  logic          rst_active, rst_asserted;
  logic          start_evt, wd_expire, wd_run, code_chg;
  logic [CW-1:0] wd_cnt, wd_lim;
  logic [HW-1:0] hold_cnt;

  // The low-supply flag syncs with reset value 1, so a fresh supply counts as low.
  sup_sync2 #(.RST_VAL(1'b1)) u_sync_scl (.clk(clk), .arst_n(por_n), .d(scl_in),   .q(scl_s));
  sup_sync2 #(.RST_VAL(1'b1)) u_sync_sda (.clk(clk), .arst_n(por_n), .d(sda_in),   .q(sda_s));
  sup_sync2 #(.RST_VAL(1'b1)) u_sync_low (.clk(clk), .arst_n(por_n), .d(low_flag), .q(low_s));

  sup_start_det u_start (
    .clk(clk), .arst_n(por_n), .enable(~rst_active),
    .scl_s(scl_s), .sda_s(sda_s), .start_evt(start_evt)
  );

  sup_wd_timer #(
    .LONG_CYC(WD_LONG_CYC), .MID_CYC(WD_MID_CYC), .SHORT_CYC(WD_SHORT_CYC)
  ) u_wd (
    .clk(clk), .arst_n(por_n), .hold(rst_active), .kick(start_evt), .code(wd_code),
    .expire(wd_expire), .run(wd_run), .code_chg(code_chg), .cnt(wd_cnt), .lim(wd_lim)
  );

  sup_hold_timer #(.HOLD_CYC(RST_HOLD_CYC)) u_hold (
    .clk(clk), .arst_n(por_n), .trig(low_s | wd_expire),
    .active(rst_active), .cnt(hold_cnt)
  );

  // The raw flag asserts reset at once; the synchronised copy times the release.
  assign rst_asserted = rst_active | low_flag;
  assign bus_block    = rst_asserted;

  if (RST_ACTIVE_HIGH) begin : g_out_high
    assign sys_rst = rst_asserted;
  end else begin : g_out_low
    assign sys_rst = ~rst_asserted;
  end
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter bit          ACTIVE_HIGH = 1'b0,
  parameter int unsigned HOLD_CYC    = 16,
  parameter int unsigned CW          = 8,
  parameter int unsigned HW          = 5
) (
  input logic          clk,
  input logic          por_n,
  input logic          low_flag,
  input logic          sys_rst,
  input logic          bus_block,
  input logic          rst_active,
  input logic          start_evt,
  input logic          wd_expire,
  input logic          wd_run,
  input logic          code_chg,
  input logic [CW-1:0] wd_cnt,
  input logic [CW-1:0] wd_lim,
  input logic [HW-1:0] hold_cnt
);
  assert_lowflag_R2: assert property (@(posedge clk) disable iff (!por_n)
    low_flag |-> (bus_block && (sys_rst == ACTIVE_HIGH)));

  assert_busblock_R11: assert property (@(posedge clk) disable iff (!por_n)
    bus_block == (sys_rst == ACTIVE_HIGH));

  assert_release_R3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_active) |-> ($past(hold_cnt) == HW'(HOLD_CYC - 1)));

  assert_expire_R8: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> (rst_active && hold_cnt == '0));

  assert_kick_R4: assert property (@(posedge clk) disable iff (!por_n)
    (start_evt && !rst_active) |=> (wd_cnt == '0));

  assert_ignore_R10: assert property (@(posedge clk) disable iff (!por_n)
    rst_active |-> !start_evt);

  assert_held_R10: assert property (@(posedge clk) disable iff (!por_n)
    rst_active |=> (wd_cnt == '0));

  assert_off_R7: assert property (@(posedge clk) disable iff (!por_n)
    !wd_run |-> !wd_expire);

  assert_bound_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wd_run && !code_chg) |-> (wd_cnt < wd_lim));

  assert_codechg_R9: assert property (@(posedge clk) disable iff (!por_n)
    code_chg |=> (wd_cnt == '0));
endmodule

bind sup_reset_gen sup_reset_gen_chk #(
  .ACTIVE_HIGH(RST_ACTIVE_HIGH), .HOLD_CYC(RST_HOLD_CYC), .CW(CW), .HW(HW)
) u_chk (
  .clk(clk), .por_n(por_n), .low_flag(low_flag), .sys_rst(sys_rst),
  .bus_block(bus_block), .rst_active(rst_active), .start_evt(start_evt),
  .wd_expire(wd_expire), .wd_run(wd_run), .code_chg(code_chg),
  .wd_cnt(wd_cnt), .wd_lim(wd_lim), .hold_cnt(hold_cnt)
);

// File: tb/sup_reset_gen_tb.sv
module sup_reset_gen_tb;
  localparam int HOLD  = 20;
  localparam int LONG  = 150;
  localparam int MID   = 90;
  localparam int SHORT = 50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       por_n = 1'b0, low_flag = 1'b0, scl = 1'b1, sda = 1'b1;
  logic [1:0] code = 2'b10;
  logic       rst_lo, blk_lo, rst_hi, blk_hi;
  int         cyc = 0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  sup_reset_gen #(.RST_ACTIVE_HIGH(1'b0), .RST_HOLD_CYC(HOLD), .WD_LONG_CYC(LONG),
                  .WD_MID_CYC(MID), .WD_SHORT_CYC(SHORT)) u_dut (
    .clk(clk), .por_n(por_n), .low_flag(low_flag), .scl_in(scl), .sda_in(sda),
    .wd_code(code), .sys_rst(rst_lo), .bus_block(blk_lo));

  sup_reset_gen #(.RST_ACTIVE_HIGH(1'b1), .RST_HOLD_CYC(HOLD), .WD_LONG_CYC(LONG),
                  .WD_MID_CYC(MID), .WD_SHORT_CYC(SHORT)) u_dut_hi (
    .clk(clk), .por_n(por_n), .low_flag(low_flag), .scl_in(scl), .sda_in(sda),
    .wd_code(code), .sys_rst(rst_hi), .bus_block(blk_hi));

  // Period by code: 00 long, 01 mid, 10 short, 11 off
  function automatic int exp_period(input logic [1:0] c);
    case (c)
      2'b00: return LONG;
      2'b01: return MID;
      2'b10: return SHORT;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_sync_release();
    return HOLD + 2;
  endfunction

  function automatic bit asserted();
    return !rst_lo;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R11: both polarities and both inhibit flags agree with the reset state
  task automatic chk_pins(input bit want);
    chk(!rst_lo == want && rst_hi == want && blk_lo == want && blk_hi == want,
        "R11 polarity/bus_block", {28'd0, rst_lo, rst_hi, blk_lo, blk_hi},
        want ? 32'b0111 : 32'b1000);
  endtask

  task automatic wait_level(input bit want, input int maxn, output int at);
    at = -1;
    for (int i = 0; i < maxn; i++) begin
      @(negedge clk);
      if (asserted() == want) begin
        at = cyc;
        return;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int c0, at, rel, a, lastk, g, L;
    bit quiet;
    void'($urandom(32'd4711));

    // Reset state while power-on is low (R1)
    idle(4);
    chk(asserted(), "R1 reset during power-on", !rst_lo, 1);
    chk_pins(1'b1);

    @(negedge clk); por_n = 1'b1; c0 = cyc;
    wait_level(1'b0, 200, at);
    chk(at - c0 == exp_sync_release(), "R1 power-on release", at - c0, exp_sync_release());
    chk_pins(1'b0);
    rel = at;

    // Short period expiry and pulse length (R6, R8)
    wait_level(1'b1, 300, at);
    chk(at - rel == exp_period(2'b10), "R6 short period", at - rel, SHORT);
    a = at;
    wait_level(1'b0, 300, at);
    chk(at - a == HOLD, "R8 watchdog pulse", at - a, HOLD);
    rel = at;

    // Look-alike activity does not kick (R5)
    idle(5);
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b1;
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b0;
    @(negedge clk); scl = 1'b1;
    wait_level(1'b1, 300, at);
    chk(at - rel == SHORT, "R5 non-start activity ignored", at - rel, SHORT);
    wait_level(1'b0, 300, rel);

    // Genuine start kicks (R4)
    idle(20);
    @(negedge clk); sda = 1'b0; c0 = cyc;
    idle(3); sda = 1'b1;
    wait_level(1'b1, 300, at);
    chk(at - c0 == SHORT + 3, "R4 start restarts watchdog", at - c0, SHORT + 3);
    a = at;

    // Start during reset is ignored (R10)
    @(negedge clk); sda = 1'b0;
    idle(3); sda = 1'b1;
    wait_level(1'b0, 300, rel);
    chk(rel - a == HOLD, "R8 watchdog pulse", rel - a, HOLD);
    wait_level(1'b1, 300, at);
    chk(at - rel == SHORT, "R10 start during reset ignored", at - rel, SHORT);
    wait_level(1'b0, 300, rel);

    // Code change clears the count (R9), mid period (R6)
    idle(10);
    @(negedge clk); code = 2'b01; c0 = cyc;
    wait_level(1'b1, 300, at);
    chk(at - c0 == MID + 1, "R9 code change restart", at - c0, MID + 1);
    wait_level(1'b0, 300, rel);
    wait_level(1'b1, 300, at);
    chk(at - rel == exp_period(2'b01), "R6 mid period", at - rel, MID);
    @(negedge clk); code = 2'b00;
    wait_level(1'b0, 300, rel);
    wait_level(1'b1, 400, at);
    chk(at - rel == exp_period(2'b00), "R6 long period", at - rel, LONG);
    wait_level(1'b0, 300, rel);

    // Low-supply flag (R2, R3)
    idle(10);
    @(negedge clk); low_flag = 1'b1;
    #1 chk(asserted(), "R2 immediate assert", !rst_lo, 1);
    chk_pins(1'b1);
    quiet = 1'b1;
    for (int i = 0; i < 3 * HOLD; i++) begin
      @(negedge clk);
      if (!asserted()) quiet = 1'b0;
    end
    chk(quiet, "R2 held while flag high", quiet, 1);
    @(negedge clk); low_flag = 1'b0; c0 = cyc;
    wait_level(1'b0, 300, at);
    chk(at - c0 == exp_sync_release(), "R3 low-flag release", at - c0, exp_sync_release());

    // Watchdog off (R7)
    @(negedge clk); code = 2'b11;
    quiet = 1'b1;
    for (int i = 0; i < 3 * LONG; i++) begin
      @(negedge clk);
      if (asserted()) quiet = 1'b0;
    end
    chk(quiet, "R7 watchdog off", !quiet, 0);

    // Random kick trains (R4)
    for (int r = 0; r < 3; r++) begin
      @(negedge clk); code = 2'($urandom_range(0, 2));
      L = exp_period(code);
      quiet = 1'b1;
      lastk = cyc;
      for (int k = 0; k < 8; k++) begin
        g = $urandom_range(6, L);
        @(negedge clk); sda = 1'b0; lastk = cyc;
        idle(2); sda = 1'b1;
        for (int i = 0; i < g - 3; i++) begin
          @(negedge clk);
          if (asserted()) quiet = 1'b0;
        end
      end
      chk(quiet, "R4 random kicks keep reset off", !quiet, 0);
      wait_level(1'b1, 400, at);
      chk(at - lastk == L + 3, "R4 expiry after last kick", at - lastk, L + 3);
      wait_level(1'b0, 300, rel);
      @(negedge clk); code = 2'b11;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule